// File: doc/BRIEF.md
# I2C Write-Only Slave Responder

This block is the target side of a two-wire serial bus. It does not drive clock. It watches the open-drain clock and data lines and detects bus start and stop conditions. It collects the first byte after a start as a seven-bit address followed by a direction bit. It then decides whether to answer. It pulls the data line low in the acknowledge slot only when three things hold: the address equals its own, the direction is a write, and the local busy input is low.

Once it has been addressed for a write, the responder takes in data bytes one after another. It acknowledges each one and hands each byte to the local logic with a one-cycle valid strobe. A controller that is not addressed, refused for a read, or refused while busy gets no acknowledge. In that case the responder stays silent until the bus is freed by a stop. Outside acknowledge slots the responder never drives the data line.

Top module: `i2c_wr_responder`

## Requirements
- R1: After reset, a fall of SDA while SCL is high starts address reception. A rise of SDA while SCL is high returns the block to idle with SDA released, and bits clocked while idle are not acknowledged.
- R2: Address bits are sampled on rising SCL, most significant bit first. The eighth bit is the direction, where 0 means write. A bit-reversed copy of the own address does not match.
- R3: When the address equals OWN_ADDR (default 7'h51), the direction is write and busy_i is low, sda_drive_o goes high after the SCL fall that ends bit 8. It stays high through the ninth clock and drops after the SCL fall that ends it.
- R4: An address that differs from OWN_ADDR is not acknowledged.
- R5: A read request (direction bit 1) to OWN_ADDR is not acknowledged.
- R6: A write request to OWN_ADDR while busy_i is high at the end of the address byte is not acknowledged.
- R7: After an unacknowledged address, all bus activity is ignored until a STOP. This includes data bytes and further STARTs: there is no acknowledge and no rx_valid_o pulse.
- R8: After an acknowledged address, each data byte is taken MSB first and acknowledged. At the SCL fall ending its bit 8, the byte appears on rx_byte_o with a one-cycle rx_valid_o pulse, in the same cycle that sda_drive_o rises.
- R9: Any number of data bytes may follow one address; each is acknowledged and reported in order until STOP.
- R10: A START in the middle of a byte discards the partial bits and restarts address reception.
- R11: Out of reset, sda_drive_o and rx_valid_o are low. sda_drive_o only changes while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| busy_i | input | 1 | Local logic cannot accept a transfer |
| sda_drive_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| rx_byte_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new rx_byte_o |

## Verification
A bit counter that is off by one shows up at the ports within the same byte. The acknowledge pull then lands a clock early or late, which shows as a missing low in the ninth slot and a corrupted received byte. A state machine stuck in the ignore state, or one that wrongly left it, shows at the very next acknowledge slot as a missing or unexpected pull. A fault in how the acknowledge state is left shows as SDA held low past the ninth clock, which the bench sees eight system cycles after that clock falls. Address-decision faults in match, direction or busy show as a wrong acknowledge in the ninth slot of the first byte.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_IGNORE
  } state_e;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned WIDTH   = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= {WIDTH{RST_VAL}};
      else if (s == 0) pipe_q[s] <= d_i;
      else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2cw_line_events.sv
module i2cw_line_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  // conditions require SCL high on both samples
  assign start_o    = scl_q & scl_s_i & sda_q & ~sda_s_i;
  assign stop_o     = scl_q & scl_s_i & ~sda_q & sda_s_i;
  assign scl_rise_o = ~scl_q & scl_s_i;
  assign scl_fall_o = scl_q & ~scl_s_i;
endmodule

// File: rtl/i2cw_shifter.sv
module i2cw_shifter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o
);
  localparam int unsigned CntW = $clog2(WIDTH + 1);

  logic [CntW-1:0]  cnt_q;
  logic [WIDTH-1:0] data_q;

  assign full_o = (cnt_q == CntW'(WIDTH));
  assign data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      data_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (shift_i && !full_o) begin
      cnt_q  <= cnt_q + 1'b1;
      data_q <= {data_q[WIDTH-2:0], bit_i};
    end
  end
endmodule

// File: rtl/i2c_wr_responder.sv
module i2c_wr_responder #(
  parameter logic [6:0]  OWN_ADDR    = 7'h51,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       busy_i,
  output logic       sda_drive_o,
  output logic [7:0] rx_byte_o,
  output logic       rx_valid_o
);
  import i2cw_pkg::*;

  localparam int unsigned ByteW = 8;

  logic [1:0]       line_s;
  logic             start, stop, scl_rise, scl_fall;
  logic             sh_clear, sh_shift, sh_full;
  logic [ByteW-1:0] sh_data;
  logic             addr_hit, ack_state, ack_end;

  state_e           state_q;
  logic             ack_hi_q, drive_q, valid_q;
  logic [ByteW-1:0] byte_q;

  i2cw_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(1'b1)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (line_s)
  );

  i2cw_line_events i_events (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (line_s[1]),
    .sda_s_i    (line_s[0]),
    .start_o    (start),
    .stop_o     (stop),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  assign ack_state = (state_q == ST_ADDR_ACK) || (state_q == ST_DATA_ACK);
  assign ack_end   = ack_state && scl_fall && ack_hi_q;
  assign sh_clear  = (start && state_q != ST_IGNORE) || ack_end;
  assign sh_shift  = scl_rise && (state_q == ST_ADDR || state_q == ST_DATA);

  i2cw_shifter #(.WIDTH(ByteW)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (sh_clear),
    .shift_i (sh_shift),
    .bit_i   (line_s[0]),
    .data_o  (sh_data),
    .full_o  (sh_full)
  );

  // address match, write direction, not busy
  assign addr_hit = (sh_data[7:1] == OWN_ADDR) && !sh_data[0] && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ack_hi_q <= 1'b0;
      drive_q  <= 1'b0;
      valid_q  <= 1'b0;
      byte_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      if (stop) begin
        state_q <= ST_IDLE;
        drive_q <= 1'b0;
      end else if (start && state_q != ST_IGNORE) begin
        state_q <= ST_ADDR;
        drive_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: if (scl_fall && sh_full) begin
            if (addr_hit) begin
              state_q  <= ST_ADDR_ACK;
              drive_q  <= 1'b1;
              ack_hi_q <= 1'b0;
            end else begin
              state_q <= ST_IGNORE;
            end
          end
          ST_DATA: if (scl_fall && sh_full) begin
            state_q  <= ST_DATA_ACK;
            drive_q  <= 1'b1;
            ack_hi_q <= 1'b0;
            byte_q   <= sh_data;
            valid_q  <= 1'b1;
          end
          ST_ADDR_ACK, ST_DATA_ACK: begin
            if (scl_rise) ack_hi_q <= 1'b1;
            else if (ack_end) begin
              drive_q <= 1'b0;
              state_q <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_drive_o = drive_q;
  assign rx_byte_o   = byte_q;
  assign rx_valid_o  = valid_q;
endmodule

// File: rtl/i2cw_chk.sv
module i2cw_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       sda_i,
  input logic       busy_i,
  input logic       sda_drive_o,
  input logic [7:0] rx_byte_o,
  input logic       rx_valid_o
);
  // R11
  drive_rise_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_drive_o) |-> !scl_i);

  // R3
  drive_fall_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_drive_o) |-> !scl_i);

  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  // R8
  valid_with_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> sda_drive_o);

  // R9
  byte_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |=> $stable(rx_byte_o) || rx_valid_o);
endmodule

bind i2c_wr_responder i2cw_chk i_chk (.*);

// File: tb/test_i2c_wr_responder.sv
`timescale 1ns/1ps
module test_i2c_wr_responder;
  localparam int H = 10;
  localparam int NV = 8;
  // {addr[6:0], rw, busy, data[7:0], expect_ack}
  localparam logic [17:0] VEC [NV] = '{
    {7'h51, 1'b0, 1'b0, 8'hA5, 1'b1},
    {7'h51, 1'b0, 1'b0, 8'h3C, 1'b1},
    {7'h50, 1'b0, 1'b0, 8'hFF, 1'b0},
    {7'h51, 1'b1, 1'b0, 8'h00, 1'b0},
    {7'h51, 1'b0, 1'b1, 8'h81, 1'b0},
    {7'h11, 1'b0, 1'b0, 8'h5A, 1'b0},
    {7'h51, 1'b0, 1'b0, 8'h00, 1'b1},
    {7'h51, 1'b0, 1'b0, 8'hFF, 1'b1}
  };

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1, busy = 0;
  logic sda_drive, rx_valid;
  logic [7:0] rx_byte, cap_byte;
  logic sda_line;
  int   n_chk = 0, n_bad = 0, cap_cnt = 0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_drive;

  i2c_wr_responder i_i2c_wr_responder (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .busy_i(busy), .sda_drive_o(sda_drive), .rx_byte_o(rx_byte),
    .rx_valid_o(rx_valid)
  );

  always @(negedge clk) if (rx_valid) begin
    cap_cnt  <= cap_cnt + 1;
    cap_byte <= rx_byte;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; w(2); scl_m = 1; w(H); sda_m = 0; w(H); scl_m = 0;
  endtask

  task automatic bus_stop();
    w(2); sda_m = 0; w(H); scl_m = 1; w(H); sda_m = 1; w(H);
  endtask

  task automatic send_bit(logic b);
    w(2); sda_m = b; w(H); scl_m = 1; w(H); scl_m = 0;
  endtask

  task automatic send_byte(logic [7:0] b, output logic acked, output logic released);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    w(2); sda_m = 1; w(8);
    a1 = !sda_line;
    scl_m = 1; w(H);
    a2 = !sda_line;
    scl_m = 0; w(8);
    acked = a1 & a2;
    released = !sda_drive;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    logic ack, rel;
    int c0;
    string req;
    w(3);
    // R11 reset state
    chk("R11 drive at reset", sda_drive, 0);
    chk("R11 valid at reset", rx_valid, 0);
    rst_n = 1; w(5);

    for (int v = 0; v < NV; v++) begin
      busy = VEC[v][9];
      req = VEC[v][0] ? "R3" : (VEC[v][9] ? "R6" : (VEC[v][10] ? "R5" : "R4"));
      if (VEC[v][17:11] == 7'h11) req = "R2";
      c0 = cap_cnt;
      bus_start();
      send_byte(VEC[v][17:10], ack, rel);
      chk(req, ack, VEC[v][0]);
      chk("R3 release after ack", rel, 1);
      send_byte(VEC[v][8:1], ack, rel);
      chk(VEC[v][0] ? "R8 data ack" : "R7 data ignored", ack, VEC[v][0]);
      chk(VEC[v][0] ? "R8 valid count" : "R7 no valid", cap_cnt - c0, VEC[v][0]);
      if (VEC[v][0]) chk("R8 data byte", cap_byte, VEC[v][8:1]);
      bus_stop();
      busy = 0;
    end

    // R2 bit-reversed own address
    bus_start(); send_byte(8'h8A, ack, rel);
    chk("R2 reversed addr", ack, 0); bus_stop();

    // R10 start in mid-byte
    bus_start();
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_start();
    send_byte(8'hA2, ack, rel);
    chk("R10 restart addr ack", ack, 1);
    bus_stop();

    // R9 several bytes in one transfer
    c0 = cap_cnt;
    bus_start(); send_byte(8'hA2, ack, rel);
    send_byte(8'h12, ack, rel); chk("R9 byte1 ack", ack, 1);
    chk("R9 byte1 value", cap_byte, 8'h12);
    send_byte(8'hED, ack, rel); chk("R9 byte2 ack", ack, 1);
    chk("R9 byte2 value", cap_byte, 8'hED);
    chk("R9 count", cap_cnt - c0, 2);
    bus_stop();

    // R7 start while ignoring does not reopen reception
    c0 = cap_cnt;
    bus_start(); send_byte(8'hA0, ack, rel); chk("R4 mismatch", ack, 0);
    bus_start(); send_byte(8'hA2, ack, rel); chk("R7 start ignored", ack, 0);
    send_byte(8'h77, ack, rel); chk("R7 data ignored", ack, 0);
    chk("R7 no valid", cap_cnt - c0, 0);
    bus_stop();
    bus_start(); send_byte(8'hA2, ack, rel); chk("R7 after stop", ack, 1);
    bus_stop();

    // R1 stop mid-data returns idle; bits without start not acked
    bus_start(); send_byte(8'hA2, ack, rel);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_stop();
    scl_m = 0;
    send_byte(8'hA2, ack, rel);
    chk("R1 idle no ack", ack, 0);
    chk("R1 idle released", sda_drive, 0);
    scl_m = 1; w(H);

    finish_run();
  end
endmodule